// File: doc/BRIEF.md
# Card-to-Host Descriptor Mode Router

This block sits between a descriptor fetch engine, the user logic and a prefetch stage of a card-to-host stream DMA. Every queue carries two context bits, a descriptor-bypass bit and a prefetch-bypass bit. Together they choose one of three modes. In cache internal mode (0,0), fetched descriptors go straight to the prefetch stage. In cache bypass mode (1,0), they leave on the bypass-out port for the user to convert, and return on the shared bypass-in port. The prefetch stage still orders them and owns the credits. In simple bypass mode (1,1), descriptors also come back on bypass-in, but the user orders them and supplies the descriptor credits. The pair (0,1) is illegal.

Descriptors from the fetch engine and from bypass-in are each routed to their own registered output, so the block needs no arbitration and no backpressure. User credits pass through only for queues whose credits the user owns. Any other user credit is rejected, is not forwarded, and pulses an error bit for that queue. A per-queue output tells the prefetch stage which queues it must credit by itself. The context table is written through a simple write port and looked up combinationally for each descriptor and each credit.

Top module: `c2h_desc_mode_router`

## Requirements
- R1: After reset, every queue is in cache internal mode, so `pf_self_credit` is all ones. All valid outputs and error outputs are 0.
- R2: A context write with `ctx_wr_en`=1 stores {`ctx_wr_desc_byp`,`ctx_wr_pfch_byp`} for `ctx_wr_qid`. Lookups see the new value from the next cycle on. A lookup in the same cycle as the write uses the old value. `pf_self_credit[q]` is the inverse of the stored prefetch-bypass bit of queue q.
- R3: A fetch-engine descriptor for a queue in mode (0,0) appears one cycle later on `pf_int_valid`, `pf_int_qid` and `pf_int_desc`, with nothing on bypass-out.
- R4: A fetch-engine descriptor for a queue whose descriptor-bypass bit is 1, in mode (1,0) or (1,1), appears one cycle later on the `bypout_*` outputs and not on `pf_int_valid`.
- R5: A bypass-in descriptor for a queue in mode (1,1) appears one cycle later on the `pf_byp_*` outputs with `pf_byp_cache`=0. For a queue in mode (1,0) it appears the same way with `pf_byp_cache`=1.
- R6: A descriptor for a queue in the illegal mode (0,1) is dropped. A drop from the fetch engine pulses `fetch_drop_err` for one cycle. A drop from bypass-in pulses `bypin_drop_err` for one cycle.
- R7: A bypass-in descriptor for a queue in mode (0,0) is dropped, and `bypin_drop_err` pulses for one cycle.
- R8: A user credit (`ucred_valid`) for a queue in mode (1,1) appears one cycle later on `cred_valid`, `cred_qid` and `cred_count`, unchanged.
- R9: A user credit for a queue in any other mode is not forwarded (`cred_valid` stays 0). Instead, bit qid of `cred_rej_err` pulses for one cycle while all its other bits stay 0.
- R10: A fetch descriptor, a bypass-in descriptor and a user credit presented in the same cycle are each handled as if presented alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ctx_wr_en | input | 1 | Context table write strobe |
| ctx_wr_qid | input | QID_W | Queue index written |
| ctx_wr_desc_byp | input | 1 | Descriptor-bypass bit to store |
| ctx_wr_pfch_byp | input | 1 | Prefetch-bypass bit to store |
| fetch_valid | input | 1 | Descriptor from the fetch engine |
| fetch_qid | input | QID_W | Queue of the fetched descriptor |
| fetch_desc | input | DESC_W | Fetched descriptor |
| bypin_valid | input | 1 | Descriptor returning from the user |
| bypin_qid | input | QID_W | Queue of the returning descriptor |
| bypin_desc | input | DESC_W | Returning descriptor |
| ucred_valid | input | 1 | User credit strobe |
| ucred_qid | input | QID_W | Queue the credit is for |
| ucred_count | input | CRED_W | Number of credits |
| pf_int_valid | output | 1 | Fetched descriptor handed to the prefetch stage |
| pf_int_qid | output | QID_W | Its queue |
| pf_int_desc | output | DESC_W | Its descriptor |
| bypout_valid | output | 1 | Fetched descriptor sent to the user |
| bypout_qid | output | QID_W | Its queue |
| bypout_desc | output | DESC_W | Its descriptor |
| pf_byp_valid | output | 1 | Returned descriptor handed to the prefetch stage |
| pf_byp_qid | output | QID_W | Its queue |
| pf_byp_desc | output | DESC_W | Its descriptor |
| pf_byp_cache | output | 1 | 1: the prefetch stage orders it (cache bypass); 0: user-ordered (simple bypass) |
| fetch_drop_err | output | 1 | Pulse: a fetched descriptor was dropped |
| bypin_drop_err | output | 1 | Pulse: a returned descriptor was dropped |
| cred_valid | output | 1 | Accepted user credit |
| cred_qid | output | QID_W | Its queue |
| cred_count | output | CRED_W | Its count |
| cred_rej_err | output | NUM_Q | Per-queue pulse: user credit rejected |
| pf_self_credit | output | NUM_Q | Per queue: 1 when the prefetch stage owns the credits |

## Verification
The assertions assume that every queue index is below NUM_Q and that `rst_n` is released away from a clock edge. They relate a routed descriptor to the stored mode of its queue. That is only meaningful when no context write happened in the cycle of the lookup, so those checks skip any cycle that follows a write. The stimulus drives inputs only at the falling edge and uses indices within range. It performs its deliberate write-then-lookup collision only in the one scenario that checks R2.

// File: rtl/c2h_route_pkg.sv
package c2h_route_pkg;

  // Mode code is {descriptor bypass bit, prefetch bypass bit}.
  typedef enum logic [1:0] {
    MODE_INTERNAL   = 2'b00,
    MODE_ILLEGAL    = 2'b01,
    MODE_CACHE_BYP  = 2'b10,
    MODE_SIMPLE_BYP = 2'b11
  } qmode_t;

  function automatic qmode_t mode_of(input logic desc_byp, input logic pfch_byp);
    return qmode_t'({desc_byp, pfch_byp});
  endfunction

endpackage

// File: rtl/c2h_ctx_table.sv
module c2h_ctx_table #(
  parameter int NUM_Q = 8,
  localparam int QID_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [QID_W-1:0] wr_qid,
  input  logic             wr_desc_byp,
  input  logic             wr_pfch_byp,
  output logic [NUM_Q-1:0] desc_byp_q,
  output logic [NUM_Q-1:0] pfch_byp_q
);

  for (genvar q = 0; q < NUM_Q; q++) begin : g_entry
    logic hit;
    logic desc_d, pfch_d;

    always_comb begin
      hit    = wr_en && (wr_qid == QID_W'(q));
      desc_d = hit ? wr_desc_byp : desc_byp_q[q];
      pfch_d = hit ? wr_pfch_byp : pfch_byp_q[q];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        desc_byp_q[q] <= 1'b0;
        pfch_byp_q[q] <= 1'b0;
      end else if (hit) begin
        desc_byp_q[q] <= desc_d;
        pfch_byp_q[q] <= pfch_d;
      end
    end
  end

endmodule

// File: rtl/c2h_fetch_steer.sv
module c2h_fetch_steer
  import c2h_route_pkg::*;
#(
  parameter int NUM_Q  = 8,
  parameter int DESC_W = 64,
  localparam int QID_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_Q-1:0]  desc_byp_vec,
  input  logic [NUM_Q-1:0]  pfch_byp_vec,
  input  logic              in_valid,
  input  logic [QID_W-1:0]  in_qid,
  input  logic [DESC_W-1:0] in_desc,
  output logic              pf_valid,
  output logic              out_valid,
  output logic              drop_err,
  output logic [QID_W-1:0]  qid_q,
  output logic [DESC_W-1:0] desc_q
);

  qmode_t mode;
  logic   pf_d, out_d, err_d;

  always_comb begin
    mode  = mode_of(desc_byp_vec[in_qid], pfch_byp_vec[in_qid]);
    pf_d  = 1'b0;
    out_d = 1'b0;
    err_d = 1'b0;
    if (in_valid) begin
      unique case (mode)
        MODE_INTERNAL:                  pf_d  = 1'b1;
        MODE_CACHE_BYP, MODE_SIMPLE_BYP: out_d = 1'b1;
        default:                        err_d = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_valid  <= 1'b0;
      out_valid <= 1'b0;
      drop_err  <= 1'b0;
    end else begin
      pf_valid  <= pf_d;
      out_valid <= out_d;
      drop_err  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qid_q  <= '0;
      desc_q <= '0;
    end else if (in_valid) begin
      qid_q  <= in_qid;
      desc_q <= in_desc;
    end
  end

endmodule

// File: rtl/c2h_bypin_steer.sv
module c2h_bypin_steer
  import c2h_route_pkg::*;
#(
  parameter int NUM_Q  = 8,
  parameter int DESC_W = 64,
  localparam int QID_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_Q-1:0]  desc_byp_vec,
  input  logic [NUM_Q-1:0]  pfch_byp_vec,
  input  logic              in_valid,
  input  logic [QID_W-1:0]  in_qid,
  input  logic [DESC_W-1:0] in_desc,
  output logic              pf_valid,
  output logic              pf_cache,
  output logic              drop_err,
  output logic [QID_W-1:0]  qid_q,
  output logic [DESC_W-1:0] desc_q
);

  qmode_t mode;
  logic   pf_d, cache_d, err_d;

  always_comb begin
    mode    = mode_of(desc_byp_vec[in_qid], pfch_byp_vec[in_qid]);
    pf_d    = 1'b0;
    cache_d = pf_cache;
    err_d   = 1'b0;
    if (in_valid) begin
      unique case (mode)
        MODE_SIMPLE_BYP: begin pf_d = 1'b1; cache_d = 1'b0; end
        MODE_CACHE_BYP:  begin pf_d = 1'b1; cache_d = 1'b1; end
        default:         err_d = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_valid <= 1'b0;
      drop_err <= 1'b0;
    end else begin
      pf_valid <= pf_d;
      drop_err <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_cache <= 1'b0;
      qid_q    <= '0;
      desc_q   <= '0;
    end else if (in_valid) begin
      pf_cache <= cache_d;
      qid_q    <= in_qid;
      desc_q   <= in_desc;
    end
  end

endmodule

// File: rtl/c2h_credit_gate.sv
module c2h_credit_gate
  import c2h_route_pkg::*;
#(
  parameter int NUM_Q  = 8,
  parameter int CRED_W = 16,
  localparam int QID_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_Q-1:0]  desc_byp_vec,
  input  logic [NUM_Q-1:0]  pfch_byp_vec,
  input  logic              in_valid,
  input  logic [QID_W-1:0]  in_qid,
  input  logic [CRED_W-1:0] in_count,
  output logic              out_valid,
  output logic [QID_W-1:0]  out_qid,
  output logic [CRED_W-1:0] out_count,
  output logic [NUM_Q-1:0]  rej_err
);

  logic             accept;
  logic             acc_d;
  logic [NUM_Q-1:0] rej_d;

  always_comb begin
    accept = (mode_of(desc_byp_vec[in_qid], pfch_byp_vec[in_qid]) == MODE_SIMPLE_BYP);
    acc_d  = in_valid && accept;
    rej_d  = '0;
    if (in_valid && !accept) rej_d[in_qid] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      rej_err   <= '0;
    end else begin
      out_valid <= acc_d;
      rej_err   <= rej_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_qid   <= '0;
      out_count <= '0;
    end else if (acc_d) begin
      out_qid   <= in_qid;
      out_count <= in_count;
    end
  end

endmodule

// File: rtl/c2h_desc_mode_router.sv
module c2h_desc_mode_router #(
  parameter int NUM_Q  = 8,
  parameter int DESC_W = 64,
  parameter int CRED_W = 16,
  localparam int QID_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctx_wr_en,
  input  logic [QID_W-1:0]  ctx_wr_qid,
  input  logic              ctx_wr_desc_byp,
  input  logic              ctx_wr_pfch_byp,
  input  logic              fetch_valid,
  input  logic [QID_W-1:0]  fetch_qid,
  input  logic [DESC_W-1:0] fetch_desc,
  input  logic              bypin_valid,
  input  logic [QID_W-1:0]  bypin_qid,
  input  logic [DESC_W-1:0] bypin_desc,
  input  logic              ucred_valid,
  input  logic [QID_W-1:0]  ucred_qid,
  input  logic [CRED_W-1:0] ucred_count,
  output logic              pf_int_valid,
  output logic [QID_W-1:0]  pf_int_qid,
  output logic [DESC_W-1:0] pf_int_desc,
  output logic              bypout_valid,
  output logic [QID_W-1:0]  bypout_qid,
  output logic [DESC_W-1:0] bypout_desc,
  output logic              pf_byp_valid,
  output logic [QID_W-1:0]  pf_byp_qid,
  output logic [DESC_W-1:0] pf_byp_desc,
  output logic              pf_byp_cache,
  output logic              fetch_drop_err,
  output logic              bypin_drop_err,
  output logic              cred_valid,
  output logic [QID_W-1:0]  cred_qid,
  output logic [CRED_W-1:0] cred_count,
  output logic [NUM_Q-1:0]  cred_rej_err,
  output logic [NUM_Q-1:0]  pf_self_credit
);

  logic [NUM_Q-1:0]  desc_byp_vec;
  logic [NUM_Q-1:0]  pfch_byp_vec;
  logic [QID_W-1:0]  f_qid;
  logic [DESC_W-1:0] f_desc;

  c2h_ctx_table #(.NUM_Q(NUM_Q)) ctx_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (ctx_wr_en),
    .wr_qid      (ctx_wr_qid),
    .wr_desc_byp (ctx_wr_desc_byp),
    .wr_pfch_byp (ctx_wr_pfch_byp),
    .desc_byp_q  (desc_byp_vec),
    .pfch_byp_q  (pfch_byp_vec)
  );

  c2h_fetch_steer #(.NUM_Q(NUM_Q), .DESC_W(DESC_W)) fetch_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .desc_byp_vec (desc_byp_vec),
    .pfch_byp_vec (pfch_byp_vec),
    .in_valid     (fetch_valid),
    .in_qid       (fetch_qid),
    .in_desc      (fetch_desc),
    .pf_valid     (pf_int_valid),
    .out_valid    (bypout_valid),
    .drop_err     (fetch_drop_err),
    .qid_q        (f_qid),
    .desc_q       (f_desc)
  );

  assign pf_int_qid  = f_qid;
  assign pf_int_desc = f_desc;
  assign bypout_qid  = f_qid;
  assign bypout_desc = f_desc;

  c2h_bypin_steer #(.NUM_Q(NUM_Q), .DESC_W(DESC_W)) bypin_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .desc_byp_vec (desc_byp_vec),
    .pfch_byp_vec (pfch_byp_vec),
    .in_valid     (bypin_valid),
    .in_qid       (bypin_qid),
    .in_desc      (bypin_desc),
    .pf_valid     (pf_byp_valid),
    .pf_cache     (pf_byp_cache),
    .drop_err     (bypin_drop_err),
    .qid_q        (pf_byp_qid),
    .desc_q       (pf_byp_desc)
  );

  c2h_credit_gate #(.NUM_Q(NUM_Q), .CRED_W(CRED_W)) cred_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .desc_byp_vec (desc_byp_vec),
    .pfch_byp_vec (pfch_byp_vec),
    .in_valid     (ucred_valid),
    .in_qid       (ucred_qid),
    .in_count     (ucred_count),
    .out_valid    (cred_valid),
    .out_qid      (cred_qid),
    .out_count    (cred_count),
    .rej_err      (cred_rej_err)
  );

  assign pf_self_credit = ~pfch_byp_vec;

endmodule

// File: rtl/c2h_desc_mode_router_chk.sv
module c2h_desc_mode_router_chk #(
  parameter int NUM_Q  = 8,
  parameter int DESC_W = 64,
  parameter int CRED_W = 16,
  localparam int QID_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctx_wr_en,
  input logic              fetch_valid,
  input logic [DESC_W-1:0] fetch_desc,
  input logic              bypin_valid,
  input logic              ucred_valid,
  input logic              pf_int_valid,
  input logic [QID_W-1:0]  pf_int_qid,
  input logic [DESC_W-1:0] pf_int_desc,
  input logic              bypout_valid,
  input logic [QID_W-1:0]  bypout_qid,
  input logic              pf_byp_valid,
  input logic [QID_W-1:0]  pf_byp_qid,
  input logic              pf_byp_cache,
  input logic              fetch_drop_err,
  input logic              bypin_drop_err,
  input logic              cred_valid,
  input logic [QID_W-1:0]  cred_qid,
  input logic [NUM_Q-1:0]  cred_rej_err,
  input logic [NUM_Q-1:0]  pf_self_credit
);

  // R3 R4 R6: a fetched descriptor goes to exactly one destination
  assert_fetch_one_dest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pf_int_valid, bypout_valid, fetch_drop_err}));

  assert_fetch_handled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |=> (pf_int_valid || bypout_valid || fetch_drop_err));

  assert_fetch_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |=> !(pf_int_valid || bypout_valid || fetch_drop_err));

  assert_pf_int_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |=> (pf_int_desc == $past(fetch_desc)));

  // R3: internal path only for queues whose credits the prefetch stage owns
  assert_internal_self_credit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_int_valid && !$past(ctx_wr_en)) |-> pf_self_credit[pf_int_qid]);

  // R5: simple bypass descriptors belong to user-credited queues, cache bypass not
  assert_bypin_kind_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_byp_valid && !$past(ctx_wr_en)) |-> (pf_byp_cache == pf_self_credit[pf_byp_qid]));

  // R7: each returned descriptor either forwarded or dropped
  assert_bypin_handled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bypin_valid |=> (pf_byp_valid ^ bypin_drop_err));

  assert_bypin_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !bypin_valid |=> !(pf_byp_valid || bypin_drop_err));

  // R8 R9: a user credit is either forwarded or rejected, never both
  assert_credit_handled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ucred_valid |=> (cred_valid ^ (|cred_rej_err)));

  assert_reject_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cred_rej_err));

  assert_credit_owner_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cred_valid && !$past(ctx_wr_en)) |-> !pf_self_credit[cred_qid]);

  // R4: bypass-out only carries descriptor-bypass queues (never the illegal kind)
  assert_bypout_not_illegal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bypout_valid && !$past(ctx_wr_en) && !pf_self_credit[bypout_qid]) |-> !fetch_drop_err);

endmodule

bind c2h_desc_mode_router c2h_desc_mode_router_chk #(
  .NUM_Q(NUM_Q), .DESC_W(DESC_W), .CRED_W(CRED_W)
) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .ctx_wr_en      (ctx_wr_en),
  .fetch_valid    (fetch_valid),
  .fetch_desc     (fetch_desc),
  .bypin_valid    (bypin_valid),
  .ucred_valid    (ucred_valid),
  .pf_int_valid   (pf_int_valid),
  .pf_int_qid     (pf_int_qid),
  .pf_int_desc    (pf_int_desc),
  .bypout_valid   (bypout_valid),
  .bypout_qid     (bypout_qid),
  .pf_byp_valid   (pf_byp_valid),
  .pf_byp_qid     (pf_byp_qid),
  .pf_byp_cache   (pf_byp_cache),
  .fetch_drop_err (fetch_drop_err),
  .bypin_drop_err (bypin_drop_err),
  .cred_valid     (cred_valid),
  .cred_qid       (cred_qid),
  .cred_rej_err   (cred_rej_err),
  .pf_self_credit (pf_self_credit)
);

// File: tb/c2h_desc_mode_router_tb_top.sv
module c2h_desc_mode_router_tb_top;

  localparam int NUM_Q  = 8;
  localparam int DESC_W = 64;
  localparam int CRED_W = 16;
  localparam int QID_W  = 3;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              ctx_wr_en, ctx_wr_desc_byp, ctx_wr_pfch_byp;
  logic [QID_W-1:0]  ctx_wr_qid;
  logic              fetch_valid, bypin_valid, ucred_valid;
  logic [QID_W-1:0]  fetch_qid, bypin_qid, ucred_qid;
  logic [DESC_W-1:0] fetch_desc, bypin_desc;
  logic [CRED_W-1:0] ucred_count;
  logic              pf_int_valid, bypout_valid, pf_byp_valid, pf_byp_cache;
  logic [QID_W-1:0]  pf_int_qid, bypout_qid, pf_byp_qid, cred_qid;
  logic [DESC_W-1:0] pf_int_desc, bypout_desc, pf_byp_desc;
  logic              fetch_drop_err, bypin_drop_err, cred_valid;
  logic [CRED_W-1:0] cred_count;
  logic [NUM_Q-1:0]  cred_rej_err, pf_self_credit;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  c2h_desc_mode_router #(.NUM_Q(NUM_Q), .DESC_W(DESC_W), .CRED_W(CRED_W)) dut_i (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    ctx_wr_en = 0; ctx_wr_qid = '0; ctx_wr_desc_byp = 0; ctx_wr_pfch_byp = 0;
    fetch_valid = 0; fetch_qid = '0; fetch_desc = '0;
    bypin_valid = 0; bypin_qid = '0; bypin_desc = '0;
    ucred_valid = 0; ucred_qid = '0; ucred_count = '0;
  endtask

  task automatic wr_ctx(input int q, input logic d, input logic p);
    ctx_wr_en = 1; ctx_wr_qid = QID_W'(q); ctx_wr_desc_byp = d; ctx_wr_pfch_byp = p;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic t_reset();
    check("R1 self credit", 64'(pf_self_credit), 64'hFF);
    check("R1 valids", 64'({pf_int_valid, bypout_valid, pf_byp_valid, cred_valid}), 0);
    check("R1 errors", 64'({fetch_drop_err, bypin_drop_err, cred_rej_err}), 0);
  endtask

  task automatic t_ctx_write();
    wr_ctx(3, 1, 1);
    check("R2 self credit q3", 64'(pf_self_credit), 64'hF7);
    wr_ctx(5, 1, 0);
    wr_ctx(6, 0, 1);
    check("R2 self credit vector", 64'(pf_self_credit), 64'hB7);
  endtask

  task automatic t_fetch_internal();
    fetch_valid = 1; fetch_qid = 1; fetch_desc = 64'hA5A5_0001_DEAD_BEEF;
    @(negedge clk); idle_inputs();
    check("R3 pf_int_valid", 64'(pf_int_valid), 1);
    check("R3 pf_int_qid", 64'(pf_int_qid), 1);
    check("R3 pf_int_desc", pf_int_desc, 64'hA5A5_0001_DEAD_BEEF);
    check("R3 no bypout", 64'(bypout_valid), 0);
  endtask

  task automatic t_fetch_bypass();
    fetch_valid = 1; fetch_qid = 3; fetch_desc = 64'h1111_2222_3333_4444;
    @(negedge clk); idle_inputs();
    check("R4 simple bypout_valid", 64'({bypout_valid, pf_int_valid}), 64'b10);
    check("R4 simple bypout data", {bypout_desc[60:0], bypout_qid}, {61'h1111_2222_3333_4444 & {61{1'b1}}, 3'd3});
    fetch_valid = 1; fetch_qid = 5; fetch_desc = 64'h5555;
    @(negedge clk); idle_inputs();
    check("R4 cache bypout_valid", 64'({bypout_valid, pf_int_valid}), 64'b10);
    check("R4 cache bypout qid", 64'(bypout_qid), 5);
    @(negedge clk);
    check("R4 bypout idle again", 64'(bypout_valid), 0);
  endtask

  task automatic t_fetch_illegal();
    fetch_valid = 1; fetch_qid = 6; fetch_desc = 64'h6666;
    @(negedge clk); idle_inputs();
    check("R6 fetch drop err", 64'(fetch_drop_err), 1);
    check("R6 fetch nothing routed", 64'({pf_int_valid, bypout_valid}), 0);
    @(negedge clk);
    check("R6 fetch err one pulse", 64'(fetch_drop_err), 0);
  endtask

  task automatic t_bypin();
    bypin_valid = 1; bypin_qid = 3; bypin_desc = 64'hC0FFEE;
    @(negedge clk); idle_inputs();
    check("R5 simple forwarded", 64'({pf_byp_valid, pf_byp_cache, bypin_drop_err}), 64'b100);
    check("R5 simple data", pf_byp_desc, 64'hC0FFEE);
    bypin_valid = 1; bypin_qid = 5; bypin_desc = 64'hBEEF5;
    @(negedge clk); idle_inputs();
    check("R5 cache forwarded", 64'({pf_byp_valid, pf_byp_cache, bypin_drop_err}), 64'b110);
    check("R5 cache qid", 64'(pf_byp_qid), 5);
    bypin_valid = 1; bypin_qid = 6; bypin_desc = 64'h6;
    @(negedge clk); idle_inputs();
    check("R6 bypin illegal dropped", 64'({pf_byp_valid, bypin_drop_err}), 64'b01);
    bypin_valid = 1; bypin_qid = 0; bypin_desc = 64'h0;
    @(negedge clk); idle_inputs();
    check("R7 bypin internal dropped", 64'({pf_byp_valid, bypin_drop_err}), 64'b01);
    @(negedge clk);
    check("R7 bypin err one pulse", 64'(bypin_drop_err), 0);
  endtask

  task automatic t_credit();
    ucred_valid = 1; ucred_qid = 3; ucred_count = 16'd7;
    @(negedge clk); idle_inputs();
    check("R8 credit accepted", 64'({cred_valid, cred_qid, cred_count}), {44'd0, 1'b1, 3'd3, 16'd7});
    check("R8 no reject", 64'(cred_rej_err), 0);
    ucred_valid = 1; ucred_qid = 5; ucred_count = 16'd9;
    @(negedge clk); idle_inputs();
    check("R9 cache bypass reject", 64'({cred_valid, cred_rej_err}), 64'h020);
    ucred_valid = 1; ucred_qid = 0; ucred_count = 16'd1;
    @(negedge clk); idle_inputs();
    check("R9 internal reject", 64'({cred_valid, cred_rej_err}), 64'h001);
    ucred_valid = 1; ucred_qid = 6; ucred_count = 16'd2;
    @(negedge clk); idle_inputs();
    check("R9 illegal reject", 64'({cred_valid, cred_rej_err}), 64'h040);
    @(negedge clk);
    check("R9 reject one pulse", 64'(cred_rej_err), 0);
  endtask

  task automatic t_write_collision();
    ctx_wr_en = 1; ctx_wr_qid = 2; ctx_wr_desc_byp = 1; ctx_wr_pfch_byp = 1;
    fetch_valid = 1; fetch_qid = 2; fetch_desc = 64'h22;
    @(negedge clk); idle_inputs();
    check("R2 same-cycle uses old mode", 64'({pf_int_valid, bypout_valid}), 64'b10);
    fetch_valid = 1; fetch_qid = 2; fetch_desc = 64'h23;
    @(negedge clk); idle_inputs();
    check("R2 next cycle uses new mode", 64'({pf_int_valid, bypout_valid}), 64'b01);
  endtask

  task automatic t_concurrent();
    fetch_valid = 1; fetch_qid = 1; fetch_desc = 64'hF1;
    bypin_valid = 1; bypin_qid = 5; bypin_desc = 64'hB5;
    ucred_valid = 1; ucred_qid = 3; ucred_count = 16'h33;
    @(negedge clk); idle_inputs();
    check("R10 fetch path", {pf_int_desc[59:0], pf_int_valid, bypout_valid, fetch_drop_err, 1'b0}, {60'hF1, 4'b1000});
    check("R10 bypin path", 64'({pf_byp_valid, pf_byp_cache, pf_byp_desc[7:0]}), 64'h3B5);
    check("R10 credit path", 64'({cred_valid, cred_count, cred_rej_err}), {39'd0, 1'b1, 16'h33, 8'h00});
  endtask

  initial begin
    #(200000 * 10);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_ctx_write();
    t_fetch_internal();
    t_fetch_bypass();
    t_fetch_illegal();
    t_bypin();
    t_credit();
    t_write_collision();
    t_concurrent();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule